// File: doc/BRIEF.md
# Memory-Mapped Seven-Segment Output Port

This block is a write-only peripheral on a processor bus with a 16-bit address, 16-bit write data and a single write strobe. It holds one 7-bit segment register for each of six seven-segment displays. Each register drives the segment lines of its display directly, so software chooses the exact lit pattern and no character decoding takes place.

The port claims the 4 KiB address region whose top four address bits equal 2. Inside that region, the low address bits pick the display: offset 0 is display 0 and offset 5 is display 5. A register loads the low seven bits of the write data on the rising clock edge of a strobed write that hits its address. Every other bus cycle leaves all registers unchanged.

Top module: `segport_top`

## Requirements
- R1: The port accepts a write only when address bits [15:12] equal 4'h2. A strobed write with any other value in those bits changes no output.
- R2: Address 0x2000+k with k in 0..5 selects display k. Only that display's output can change on such a write.
- R3: A strobed write that selects display k loads write-data bits [6:0] into that display's output on the same rising clock edge. The new value is visible after that edge.
- R4: Each output bit maps to one segment. Bit 0 is the top segment. Bits 1 to 5 go clockwise: upper right, lower right, bottom, lower left, upper left. Bit 6 is the middle segment. A value of 7'h00 lights no segment, 7'h7F lights every segment, and 7'b1101101 shows the digit 5. Values pass through unchanged.
- R5: While `rst` is high at a rising edge, all six outputs become 7'h00 on that edge. This reset is synchronous and active high.
- R6: Strobed writes to offsets 0x006 through 0xFFF inside the region change no output.
- R7: Write-data bits [15:7] have no effect on the stored value.
- R8: When `bus_wr` is low, no output changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; blanks all displays |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data; only bits [6:0] are stored |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| seg_d0 | output | 7 | Segment pattern for display 0 |
| seg_d1 | output | 7 | Segment pattern for display 1 |
| seg_d2 | output | 7 | Segment pattern for display 2 |
| seg_d3 | output | 7 | Segment pattern for display 3 |
| seg_d4 | output | 7 | Segment pattern for display 4 |
| seg_d5 | output | 7 | Segment pattern for display 5 |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and `bus_wr` are stable and known at each rising edge, and that a strobe lasts a single cycle per intended write.

The stimulus meets these assumptions in the following way:
- It changes every bus input only on the falling clock edge.
- It raises `bus_wr` for exactly one cycle per write.
- It drops `bus_wr` before sampling the outputs at the next falling edge.

Beyond that, the directed writes aim at each offset inside the region, the region edges (0x2006, 0x2FFF) and the neighbouring regions. They also use data words that set the ignored upper bits.

// File: rtl/segport_pkg.sv
package segport_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int SEG_W     = 7;
    localparam int N_DISP    = 6;
    localparam int REGION_LO = 12;
    localparam int REGION_W  = ADDR_W - REGION_LO;
    localparam logic [REGION_W-1:0] REGION_ID = REGION_W'(2);

    typedef logic [SEG_W-1:0] seg_pat_t;

    typedef struct packed {
        logic     strobe;
        seg_pat_t pattern;
    } seg_wr_t;

    function automatic logic region_hit(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:REGION_LO] == REGION_ID;
    endfunction

endpackage

// File: rtl/segport_decode.sv
module segport_decode
    import segport_pkg::*;
#(
    parameter int NUM = N_DISP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic [NUM-1:0]      load_sel
);
    localparam int OFF_W = REGION_LO;

    logic                 hit;
    logic [OFF_W-1:0]     offset;

    assign hit    = region_hit(addr);
    assign offset = addr[OFF_W-1:0];

    for (genvar k = 0; k < NUM; k++) begin : g_sel
        assign load_sel[k] = wr && hit && (offset == OFF_W'(k));
    end

    // R2: at most one display is picked by any bus cycle
    assert_one_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_sel));

endmodule

// File: rtl/segport_bank.sv
module segport_bank
    import segport_pkg::*;
#(
    parameter int NUM = N_DISP,
    parameter int W   = SEG_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM-1:0]          load_sel,
    input  logic [W-1:0]            pattern,
    output logic [NUM-1:0][W-1:0]   seg_q
);
    for (genvar k = 0; k < NUM; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                seg_q[k] <= '0;
            else if (load_sel[k])
                seg_q[k] <= pattern;
        end

        // R3: selected register takes the presented pattern
        assert_load_R3: assert property (@(posedge clk) disable iff (rst)
            load_sel[k] |=> seg_q[k] == $past(pattern));

        // R8: unselected register keeps its value
        assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !load_sel[k] |=> $stable(seg_q[k]));
    end

    // R5: reset blanks every register
    assert_reset_blank_R5: assert property (@(posedge clk)
        rst |=> seg_q == '0);

endmodule

// File: rtl/segport_top.sv
module segport_top
    import segport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        bus_addr,
    input  logic [15:0]        bus_wdata,
    input  logic               bus_wr,
    output logic [6:0]         seg_d0,
    output logic [6:0]         seg_d1,
    output logic [6:0]         seg_d2,
    output logic [6:0]         seg_d3,
    output logic [6:0]         seg_d4,
    output logic [6:0]         seg_d5
);
    logic [N_DISP-1:0]            load_sel;
    logic [N_DISP-1:0][SEG_W-1:0] seg_q;
    seg_wr_t                      wreq;
    logic                         unused_hi_data;

    assign wreq.strobe  = bus_wr;
    assign wreq.pattern = bus_wdata[SEG_W-1:0];
    assign unused_hi_data = ^bus_wdata[DATA_W-1:SEG_W];

    segport_decode #(.NUM(N_DISP)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (wreq.strobe),
        .load_sel (load_sel)
    );

    segport_bank #(.NUM(N_DISP), .W(SEG_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .load_sel (load_sel),
        .pattern  (wreq.pattern),
        .seg_q    (seg_q)
    );

    assign seg_d0 = seg_q[0];
    assign seg_d1 = seg_q[1];
    assign seg_d2 = seg_q[2];
    assign seg_d3 = seg_q[3];
    assign seg_d4 = seg_q[4];
    assign seg_d5 = seg_q[5];

    // R1: writes outside the region leave every output alone
    assert_region_only_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[15:12] != 4'h2) |=> $stable(seg_q));

    // R6: writes to unused offsets inside the region leave every output alone
    assert_high_offset_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[15:12] == 4'h2 && bus_addr[11:0] > 12'd5)
        |=> $stable(seg_q));

endmodule

// File: tb/segport_top_bench.sv
module segport_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  d [6];
    logic [6:0]  exp_v [6];
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    segport_top u_segport_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr),
        .seg_d0(d[0]), .seg_d1(d[1]), .seg_d2(d[2]),
        .seg_d3(d[3]), .seg_d4(d[4]), .seg_d5(d[5])
    );

    task automatic check_all(input string req);
        for (int k = 0; k < 6; k++) begin
            n_checks++;
            if (d[k] !== exp_v[k]) begin
                n_fail++;
                $display("FAIL %s display %0d: actual %h expected %h", req, k, d[k], exp_v[k]);
            end
        end
    endtask

    // one strobed cycle; outputs sampled at the following falling edge
    task automatic bus_cycle(input logic [15:0] a, input logic [15:0] wd, input logic w);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_wr = w;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) exp_v[k] = '0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check_all("R5 reset");
    endtask

    task automatic t_each_display();
        for (int k = 0; k < 6; k++) begin
            bus_cycle(16'h2000 + 16'(k), 16'(7'h11 * (k + 1)), 1'b1);
            exp_v[k] = 7'(7'h11 * (k + 1));
            check_all("R2/R3 per-display write");
        end
    endtask

    task automatic t_patterns();
        bus_cycle(16'h2005, 16'h0000, 1'b1); exp_v[5] = 7'h00;
        check_all("R4 all off");
        bus_cycle(16'h2005, 16'h007F, 1'b1); exp_v[5] = 7'h7F;
        check_all("R4 all on");
        bus_cycle(16'h2005, 16'h006D, 1'b1); exp_v[5] = 7'b1101101;
        check_all("R4 digit five");
        bus_cycle(16'h2000, 16'h0001, 1'b1); exp_v[0] = 7'h01;
        check_all("R4 top segment only");
    endtask

    task automatic t_other_regions();
        bus_cycle(16'h0000, 16'h007F, 1'b1); check_all("R1 region 0");
        bus_cycle(16'h1001, 16'h007F, 1'b1); check_all("R1 region 1");
        bus_cycle(16'h3002, 16'h007F, 1'b1); check_all("R1 region 3");
        bus_cycle(16'hA003, 16'h007F, 1'b1); check_all("R1 region A");
        bus_cycle(16'h6004, 16'h007F, 1'b1); check_all("R1 region 6");
    endtask

    task automatic t_high_offsets();
        bus_cycle(16'h2006, 16'h0055, 1'b1); check_all("R6 offset 6");
        bus_cycle(16'h2FFF, 16'h0055, 1'b1); check_all("R6 offset FFF");
        bus_cycle(16'h2100, 16'h0055, 1'b1); check_all("R6 offset 100");
        bus_cycle(16'h2010, 16'h0055, 1'b1); check_all("R6 offset 10");
    endtask

    task automatic t_upper_data();
        bus_cycle(16'h2002, 16'hFF92, 1'b1); exp_v[2] = 7'h12;
        check_all("R7 upper data ignored");
        bus_cycle(16'h2003, 16'h8000, 1'b1); exp_v[3] = 7'h00;
        check_all("R7 only bit 15 set");
    endtask

    task automatic t_no_strobe();
        bus_cycle(16'h2001, 16'h0033, 1'b0); check_all("R8 no strobe");
        bus_cycle(16'h2004, 16'h0000, 1'b0); check_all("R8 no strobe zero");
    endtask

    task automatic t_reset_after_use();
        do_reset();
        check_all("R5 reset after writes");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_each_display();
        t_patterns();
        t_other_regions();
        t_high_offsets();
        t_upper_data();
        t_no_strobe();
        t_reset_after_use();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule